// File: doc/BRIEF.md
# Packet Timestamp Capture Controller

This block records when transmitted packets cross a boundary. It holds a free-running timer and a second counter of how many times that timer has wrapped. A 2-bit mode input chooses which boundary strobe, if any, latches both counters into a pair of readable capture registers. The strobes are the start of a packet, taken right after its sync word, and the end of a packet. The timer and the wrap counter are latched on the same clock edge, so the captured pair always describes one instant.

The mode can also capture only the start of the first packet of a task. In that mode an internal armed flag is cleared by the first start capture and set again by the task-start strobe. A valid flag tells software that a fresh timestamp is waiting. A read acknowledge clears it.

Top module: `pkt_stamp_capture`

## Requirements
- R1: After reset, the timer, wrap count, both capture registers and the valid flag are all zero.
- R2: The timer increments by one every clock. When it is all ones it wraps to zero on the next clock, and the wrap count increments by one on that same clock.
- R3: With mode 2'b00, neither boundary strobe captures.
- R4: With mode 2'b01, every start strobe captures, and end strobes are ignored.
- R5: With mode 2'b10, every end strobe captures, and start strobes are ignored.
- R6: With mode 2'b11, a start strobe captures only while armed, and that capture disarms. Further start strobes and all end strobes are ignored while disarmed. The block is armed after reset.
- R7: A task-start strobe re-arms the mode-2'b11 capture from the following clock. A start strobe in the same clock as the task start sees the old armed state.
- R8: A capture loads the capture registers with the timer and wrap count present at the capturing edge. The cycle with the highest timer value before a wrap is included.
- R9: A capture sets the valid flag, and a read acknowledge clears it. When both occur in one clock, the valid flag is set.
- R10: Without a capture, the capture registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txCapMode | input | 2 | Transmit capture mode (00 off, 01 every start, 10 every end, 11 first start only) |
| sopStrobe | input | 1 | Packet start, after the sync word |
| eopStrobe | input | 1 | Packet end |
| taskStart | input | 1 | New task begins; re-arms the first-start mode |
| readAck | input | 1 | Timestamp has been read; clears the valid flag |
| capFire | output | 1 | High in the cycle a capture is taken |
| timerCount | output | CNT_W | Free-running timer |
| timerOverflow | output | OVF_W | Number of timer wraps |
| capCount | output | CNT_W | Captured timer value |
| capOverflow | output | OVF_W | Captured wrap count |
| capValid | output | 1 | A capture is waiting to be read |

## Verification
The bench builds the block with a 4-bit timer and a 6-bit wrap counter. With these widths the timer wraps every 16 cycles, so captures land on both sides of a wrap during a short run. This also makes it possible to capture exactly at the all-ones value and to check that the wrap count advances together with the timer. The default widths of 16 and 24 bits would need tens of thousands of cycles to show one wrap.

// File: rtl/pkt_stamp_pkg.sv
package pkt_stamp_pkg;
  typedef enum logic [1:0] {
    CAP_OFF   = 2'b00,
    CAP_START = 2'b01,
    CAP_END   = 2'b10,
    CAP_FIRST = 2'b11
  } capMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clearValid;
  } capCtl_t;
endpackage

// File: rtl/pkt_stamp_ctrl.sv
module pkt_stamp_ctrl
  import pkt_stamp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  capMode_e mode,
  input  logic     sopStrobe,
  input  logic     eopStrobe,
  input  logic     taskStart,
  input  logic     readAck,
  output capCtl_t  ctl
);
  logic armed;
  logic fire;

  always_comb begin
    unique case (mode)
      CAP_OFF:   fire = 1'b0;
      CAP_START: fire = sopStrobe;
      CAP_END:   fire = eopStrobe;
      CAP_FIRST: fire = sopStrobe && armed;
      default:   fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b1;
    end else if (taskStart) begin
      armed <= 1'b1;
    end else if (fire && mode == CAP_FIRST) begin
      armed <= 1'b0;
    end
  end

  assign ctl.capture    = fire;
  assign ctl.clearValid = readAck;
endmodule

// File: rtl/pkt_stamp_dpath.sv
module pkt_stamp_dpath
  import pkt_stamp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OVF_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  capCtl_t          ctl,
  output logic [CNT_W-1:0] timerCount,
  output logic [OVF_W-1:0] timerOverflow,
  output logic [CNT_W-1:0] capCount,
  output logic [OVF_W-1:0] capOverflow,
  output logic             capValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrap;
  assign wrap = (timerCount == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCount    <= '0;
      timerOverflow <= '0;
    end else begin
      timerCount <= timerCount + CNT_W'(1);
      if (wrap) timerOverflow <= timerOverflow + OVF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capCount    <= '0;
      capOverflow <= '0;
    end else if (ctl.capture) begin
      capCount    <= timerCount;
      capOverflow <= timerOverflow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               capValid <= 1'b0;
    else if (ctl.capture)    capValid <= 1'b1;
    else if (ctl.clearValid) capValid <= 1'b0;
  end
endmodule

// File: rtl/pkt_stamp_capture.sv
module pkt_stamp_capture
  import pkt_stamp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OVF_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       txCapMode,
  input  logic             sopStrobe,
  input  logic             eopStrobe,
  input  logic             taskStart,
  input  logic             readAck,
  output logic             capFire,
  output logic [CNT_W-1:0] timerCount,
  output logic [OVF_W-1:0] timerOverflow,
  output logic [CNT_W-1:0] capCount,
  output logic [OVF_W-1:0] capOverflow,
  output logic             capValid
);
  capCtl_t ctl;

  pkt_stamp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (capMode_e'(txCapMode)),
    .sopStrobe (sopStrobe),
    .eopStrobe (eopStrobe),
    .taskStart (taskStart),
    .readAck   (readAck),
    .ctl       (ctl)
  );

  pkt_stamp_dpath #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .timerCount    (timerCount),
    .timerOverflow (timerOverflow),
    .capCount      (capCount),
    .capOverflow   (capOverflow),
    .capValid      (capValid)
  );

  assign capFire = ctl.capture;
endmodule

// File: rtl/pkt_stamp_capture_chk.sv
module pkt_stamp_capture_chk #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       txCapMode,
  input logic             sopStrobe,
  input logic             eopStrobe,
  input logic             readAck,
  input logic             capFire,
  input logic [CNT_W-1:0] timerCount,
  input logic [OVF_W-1:0] timerOverflow,
  input logic [CNT_W-1:0] capCount,
  input logic [OVF_W-1:0] capOverflow,
  input logic             capValid
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R2
  timer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerCount != TOP) |=> (timerCount == $past(timerCount) + CNT_W'(1)));

  // R2
  timer_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerCount == TOP) |=> (timerCount == '0 && timerOverflow == $past(timerOverflow) + OVF_W'(1)));

  // R3
  mode_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCapMode == 2'b00) |-> !capFire);

  // R5
  end_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCapMode == 2'b10) |-> (capFire == eopStrobe));

  // R8
  cap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    capFire |=> (capCount == $past(timerCount) && capOverflow == $past(timerOverflow)));

  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capFire |=> ($stable(capCount) && $stable(capOverflow)));

  // R9
  valid_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    capFire |=> capValid);

  // R9
  valid_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readAck && !capFire) |=> !capValid);

  // R4
  start_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCapMode == 2'b01) |-> (capFire == sopStrobe));
endmodule

bind pkt_stamp_capture pkt_stamp_capture_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .txCapMode     (txCapMode),
  .sopStrobe     (sopStrobe),
  .eopStrobe     (eopStrobe),
  .readAck       (readAck),
  .capFire       (capFire),
  .timerCount    (timerCount),
  .timerOverflow (timerOverflow),
  .capCount      (capCount),
  .capOverflow   (capOverflow),
  .capValid      (capValid)
);

// File: tb/test_pkt_stamp_capture.sv
`timescale 1ns/1ps
module test_pkt_stamp_capture;
  localparam int CNT_W = 4;
  localparam int OVF_W = 6;
  localparam int NVEC  = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] txCapMode = 2'b00;
  logic sopStrobe = 1'b0, eopStrobe = 1'b0, taskStart = 1'b0, readAck = 1'b0;
  logic capFire, capValid;
  logic [CNT_W-1:0] timerCount, capCount;
  logic [OVF_W-1:0] timerOverflow, capOverflow;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pkt_stamp_capture #(.CNT_W(CNT_W), .OVF_W(OVF_W)) i_pkt_stamp_capture (
    .clk(clk), .rstN(rstN), .txCapMode(txCapMode), .sopStrobe(sopStrobe),
    .eopStrobe(eopStrobe), .taskStart(taskStart), .readAck(readAck),
    .capFire(capFire), .timerCount(timerCount), .timerOverflow(timerOverflow),
    .capCount(capCount), .capOverflow(capOverflow), .capValid(capValid)
  );

  // {mode[1:0], sop, eop, task, ack, expFire, expValidAfter}
  localparam logic [7:0] VEC [NVEC] = '{
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 start ignored
    {2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 end ignored
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 start captures
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 end ignored
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 every start
    {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 start ignored
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 end captures
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R9 capture beats ack
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 ack clears
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 armed from reset
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 disarmed
    {2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 end ignored
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 re-arm
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 capture after re-arm
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 disarmed again
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 not gated by arming
    {2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 same-cycle sees old state
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}  // R7 armed next cycle
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    txCapMode = 2'b00; sopStrobe = 1'b0; eopStrobe = 1'b0;
    taskStart = 1'b0; readAck = 1'b0;
  endtask

  logic [CNT_W-1:0] expCnt;
  logic [OVF_W-1:0] expOvf;

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    expCnt = '0;
    expOvf = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(timerCount == 0 && timerOverflow == 0, "R1", "timer", timerCount, 0);
    check(capCount == 0 && capOverflow == 0, "R1", "capture", capCount, 0);
    check(capValid == 1'b0, "R1", "valid", capValid, 0);
    rstN = 1'b1;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [CNT_W-1:0] tc;
      logic [OVF_W-1:0] to;
      @(negedge clk);
      {txCapMode, sopStrobe, eopStrobe, taskStart, readAck} = VEC[i][7:2];
      tc = timerCount;
      to = timerOverflow;
      #1;
      check(capFire == VEC[i][1], "R3-R7 vector", "capFire", capFire, VEC[i][1]);
      if (VEC[i][1]) begin
        expCnt = tc;
        expOvf = to;
      end
      @(negedge clk);
      idle();
      // R8 / R10 capture contents
      check(capCount == expCnt, "R8", "capCount", capCount, expCnt);
      check(capOverflow == expOvf, "R8", "capOverflow", capOverflow, expOvf);
      // R9 valid flag
      check(capValid == VEC[i][0], "R9", "capValid", capValid, VEC[i][0]);
    end

    // R2 wrap: wait for all-ones, then step
    begin
      logic [OVF_W-1:0] ovfBefore;
      for (int k = 0; k < 40 && timerCount != '1; k++) @(negedge clk);
      check(timerCount == '1, "R2", "reached top", timerCount, 15);
      ovfBefore = timerOverflow;
      // R8 capture exactly at the top value
      txCapMode = 2'b01; sopStrobe = 1'b1;
      @(negedge clk);
      idle();
      check(timerCount == 0, "R2", "wrap to zero", timerCount, 0);
      check(timerOverflow == ovfBefore + 1'b1, "R2", "overflow step",
            timerOverflow, ovfBefore + 1'b1);
      check(capCount == 4'hF, "R8", "capCount at top", capCount, 15);
      check(capOverflow == ovfBefore, "R8", "capOverflow at top", capOverflow, ovfBefore);
      @(negedge clk);
      check(timerCount == 1, "R2", "increment", timerCount, 1);
      // R10 hold across idle cycles
      repeat (5) @(negedge clk);
      check(capCount == 4'hF && capOverflow == ovfBefore, "R10", "hold",
            capCount, 15);
    end

    // R1 reset mid-run clears state and re-arms first-start mode
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(capValid == 0 && capCount == 0 && timerCount == 0, "R1", "re-reset",
          capCount, 0);
    txCapMode = 2'b11; sopStrobe = 1'b1;
    #1;
    check(capFire == 1'b1, "R6", "armed after reset", capFire, 1);
    @(negedge clk);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule